// File: doc/BRIEF.md
# Retirement Stall Cycle Monitor

This block watches the retirement stream of an in-order pipeline and keeps a cycle account of it. Each retirement beat describes one instruction. It gives the register a load writes, up to two source registers with their own valid flags, whether the instruction is a branch and whether that branch was taken, the base cycle cost, and two flags that mark the first and the last instruction of an issue slot. A single instruction has both flags set. A dual-issue pair sends its first instruction with only the first flag and its second instruction with only the last flag.

A source register that was loaded by the instruction accounted just before is charged a load-use penalty. A taken branch is charged a branch penalty. Penalties build up across an issue slot. The total cycle counter advances once per slot, by the cost of the dearer instruction. Load-stall and branch-stall totals, and the taken and not-taken branch counts, are kept in separate 32-bit counters that wrap modulo 2^32.

The retirement input is a valid/ready stream. `in_ready` is high in every cycle, so the monitor never applies back-pressure. A beat is accepted on a rising clock edge where `in_valid` is high, and every counter shows the effect of that beat from the next cycle on.

Top module: `stall_monitor`

## Requirements
- R1: A synchronous reset clears all five counters to zero, and `in_ready` is 1 in every cycle.
- R2: A load marks its destination in a pending register mask. That mask becomes the active mask once the load's own beat is accounted, so only the next accepted instruction sees it. Each valid source whose register is set in the active mask adds 2 to the instruction's load stall, which makes 4 when both sources hit.
- R3: A source whose valid flag is 0 is never checked against the active mask and adds no stall, whatever its register number.
- R4: A taken branch adds 2 to the branch stall and adds 1 to `taken_branches`. A branch that is not taken adds 1 to `untaken_branches` and no stall. A beat that is not a branch changes neither branch count.
- R5: An instruction's cost is its base cycles plus its accumulated load stall plus its accumulated branch stall. A single instruction (first=1, last=1) advances `total_cycles` by that cost.
- R6: A first beat clears the stall accumulators, the pending mask and the slot maximum. A beat with last=0 leaves `total_cycles` unchanged and records its cost as the slot maximum. A following beat with first=0 and last=1 keeps the accumulators and the pending mask, and advances `total_cycles` by the larger of its own cost and the slot maximum.
- R7: On every accepted beat, `load_stall_cycles` and `branch_stall_cycles` advance by the current accumulated values of the slot. For a pair, the second beat therefore adds the first beat's stalls again.
- R8: A cycle with `in_valid` = 0 changes no counter and no mask, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A retirement beat is present |
| in_ready | output | 1 | Always 1; the beat is accepted when valid |
| in_first | input | 1 | First instruction of the issue slot |
| in_last | input | 1 | Last instruction of the issue slot |
| in_is_load | input | 1 | The instruction is a load |
| in_load_dst | input | 4 | Register written by the load |
| in_src0_valid | input | 1 | Source 0 is used |
| in_src0 | input | 4 | Source 0 register |
| in_src1_valid | input | 1 | Source 1 is used |
| in_src1 | input | 4 | Source 1 register |
| in_is_branch | input | 1 | The instruction is a branch |
| in_taken | input | 1 | The branch was taken |
| in_base_cycles | input | 8 | Base cycle cost |
| total_cycles | output | 32 | Slot-wise total cycle count |
| load_stall_cycles | output | 32 | Accumulated load-use stall |
| branch_stall_cycles | output | 32 | Accumulated branch stall |
| taken_branches | output | 32 | Count of taken branches |
| untaken_branches | output | 32 | Count of branches not taken |

## Verification
Two functions can land on the same beat: a load-use hit and a taken-branch penalty. Both then feed one instruction cost, and in a pair they also meet the maximum selection. The bench provokes this with directed beats in which a taken branch reads a register loaded just before, and with random pairs that draw sources from a small register range so hits are frequent. After every beat, all five counters are compared with a reference model in the bench that follows the requirements.

// File: rtl/stall_mon_pkg.sv
package stall_mon_pkg;
  localparam int CNT_W = 32;
  localparam int NCNT  = 5;
  typedef enum logic [2:0] {
    C_TOTAL  = 3'd0,
    C_LDST   = 3'd1,
    C_BRST   = 3'd2,
    C_TAKEN  = 3'd3,
    C_UNTAKE = 3'd4
  } cnt_sel_e;
endpackage

// File: rtl/sb_track.sv
module sb_track #(
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          first,
  input  logic          is_load,
  input  logic [IW-1:0] dst,
  input  logic          s0_v,
  input  logic [IW-1:0] s0,
  input  logic          s1_v,
  input  logic [IW-1:0] s1,
  output logic          hit0,
  output logic          hit1
);
  logic [NREG-1:0] active_q, pend_q, pend_base, pend_next;

  assign hit0 = s0_v && active_q[s0];
  assign hit1 = s1_v && active_q[s1];

  always_comb begin
    pend_base = first ? '0 : pend_q;
    pend_next = pend_base;
    if (is_load) pend_next[dst] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
      pend_q   <= '0;
    end else if (fire) begin
      pend_q   <= pend_next;
      active_q <= pend_next;
    end
  end
endmodule

// File: rtl/slot_cost.sv
module slot_cost #(
  parameter int BASE_W = 8,
  parameter int ACC_W  = 16,
  localparam int COST_W = ACC_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              first,
  input  logic              last,
  input  logic [BASE_W-1:0] base,
  input  logic              hit0,
  input  logic              hit1,
  input  logic              br_taken,
  output logic [ACC_W-1:0]  ld_now,
  output logic [ACC_W-1:0]  br_now,
  output logic [COST_W-1:0] charge
);
  logic [ACC_W-1:0]  ld_acc_q, br_acc_q, ld_base, br_base;
  logic [COST_W-1:0] max_q, max_base, cost;

  always_comb begin
    ld_base  = first ? '0 : ld_acc_q;
    br_base  = first ? '0 : br_acc_q;
    max_base = first ? '0 : max_q;
    ld_now   = ld_base + ((ACC_W'(hit0) + ACC_W'(hit1)) << 1);
    br_now   = br_base + (br_taken ? ACC_W'(2) : '0);
    cost     = COST_W'(base) + COST_W'(ld_now) + COST_W'(br_now);
    charge   = (cost > max_base) ? cost : max_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_acc_q <= '0;
      br_acc_q <= '0;
      max_q    <= '0;
    end else if (fire) begin
      ld_acc_q <= ld_now;
      br_acc_q <= br_now;
      if (!last) max_q <= cost;
    end
  end
endmodule

// File: rtl/counter_bank.sv
module counter_bank
  import stall_mon_pkg::*;
#(
  parameter int N = NCNT,
  parameter int W = CNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        en,
  input  logic [N-1:0][W-1:0] inc,
  output logic [N-1:0][W-1:0] val
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)        val[i] <= '0;
      else if (en[i]) val[i] <= val[i] + inc[i];
    end
  end
endmodule

// File: rtl/stall_monitor.sv
module stall_monitor
  import stall_mon_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int BASE_W = 8,
  parameter int ACC_W  = 16,
  localparam int IW    = $clog2(NREG),
  localparam int COST_W = ACC_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_first,
  input  logic              in_last,
  input  logic              in_is_load,
  input  logic [IW-1:0]     in_load_dst,
  input  logic              in_src0_valid,
  input  logic [IW-1:0]     in_src0,
  input  logic              in_src1_valid,
  input  logic [IW-1:0]     in_src1,
  input  logic              in_is_branch,
  input  logic              in_taken,
  input  logic [BASE_W-1:0] in_base_cycles,
  output logic [CNT_W-1:0]  total_cycles,
  output logic [CNT_W-1:0]  load_stall_cycles,
  output logic [CNT_W-1:0]  branch_stall_cycles,
  output logic [CNT_W-1:0]  taken_branches,
  output logic [CNT_W-1:0]  untaken_branches
);
  logic fire, hit0, hit1, br_tk;
  logic [ACC_W-1:0]  ld_now, br_now;
  logic [COST_W-1:0] charge;
  logic [NCNT-1:0]            cen;
  logic [NCNT-1:0][CNT_W-1:0] cinc, cval;

  assign in_ready = 1'b1;
  assign fire     = in_valid && in_ready;
  assign br_tk    = in_is_branch && in_taken;

  sb_track #(.NREG(NREG)) u_sb (
    .clk(clk), .rst(rst), .fire(fire), .first(in_first),
    .is_load(in_is_load), .dst(in_load_dst),
    .s0_v(in_src0_valid), .s0(in_src0), .s1_v(in_src1_valid), .s1(in_src1),
    .hit0(hit0), .hit1(hit1)
  );

  slot_cost #(.BASE_W(BASE_W), .ACC_W(ACC_W)) u_cost (
    .clk(clk), .rst(rst), .fire(fire), .first(in_first), .last(in_last),
    .base(in_base_cycles), .hit0(hit0), .hit1(hit1), .br_taken(br_tk),
    .ld_now(ld_now), .br_now(br_now), .charge(charge)
  );

  always_comb begin
    cen          = '0;
    cinc         = '0;
    cen[C_TOTAL]  = fire && in_last;
    cinc[C_TOTAL] = CNT_W'(charge);
    cen[C_LDST]   = fire;
    cinc[C_LDST]  = CNT_W'(ld_now);
    cen[C_BRST]   = fire;
    cinc[C_BRST]  = CNT_W'(br_now);
    cen[C_TAKEN]  = fire && br_tk;
    cinc[C_TAKEN] = CNT_W'(1);
    cen[C_UNTAKE] = fire && in_is_branch && !in_taken;
    cinc[C_UNTAKE] = CNT_W'(1);
  end

  counter_bank #(.N(NCNT), .W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(cen), .inc(cinc), .val(cval)
  );

  assign total_cycles        = cval[C_TOTAL];
  assign load_stall_cycles   = cval[C_LDST];
  assign branch_stall_cycles = cval[C_BRST];
  assign taken_branches      = cval[C_TAKEN];
  assign untaken_branches    = cval[C_UNTAKE];
endmodule

// File: rtl/stall_monitor_chk.sv
module stall_monitor_chk #(
  parameter int IW = 4,
  parameter int BW = 8,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_first,
  input logic          in_last,
  input logic          in_src0_valid,
  input logic          in_src1_valid,
  input logic          in_is_branch,
  input logic          in_taken,
  input logic [CW-1:0] total_cycles,
  input logic [CW-1:0] load_stall_cycles,
  input logic [CW-1:0] branch_stall_cycles,
  input logic [CW-1:0] taken_branches,
  input logic [CW-1:0] untaken_branches
);
  a_r1_ready_high: assert property (@(posedge clk) disable iff (rst) in_ready);

  a_r4_taken_inc: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_is_branch && in_taken |=> taken_branches == $past(taken_branches) + 1);

  a_r4_untaken_inc: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_is_branch && !in_taken |=> untaken_branches == $past(untaken_branches) + 1);

  a_r4_first_taken_stall: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_first && in_is_branch && in_taken
    |=> branch_stall_cycles == $past(branch_stall_cycles) + 2);

  a_r3_no_src_no_stall: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_first && !in_src0_valid && !in_src1_valid |=> $stable(load_stall_cycles));

  a_r6_hold_total: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_last |=> $stable(total_cycles));

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(total_cycles) && $stable(load_stall_cycles) &&
                  $stable(branch_stall_cycles) && $stable(taken_branches) &&
                  $stable(untaken_branches));
endmodule

bind stall_monitor stall_monitor_chk #(.IW(IW), .BW(BASE_W), .CW(32)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_first(in_first), .in_last(in_last),
  .in_src0_valid(in_src0_valid), .in_src1_valid(in_src1_valid),
  .in_is_branch(in_is_branch), .in_taken(in_taken),
  .total_cycles(total_cycles), .load_stall_cycles(load_stall_cycles),
  .branch_stall_cycles(branch_stall_cycles), .taken_branches(taken_branches),
  .untaken_branches(untaken_branches)
);

// File: tb/tb_stall_monitor.sv
`timescale 1ns/1ps
module tb_stall_monitor;
  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready, in_first = 0, in_last = 0, in_is_load = 0;
  logic [3:0] in_load_dst = 0, in_src0 = 0, in_src1 = 0;
  logic in_src0_valid = 0, in_src1_valid = 0, in_is_branch = 0, in_taken = 0;
  logic [7:0] in_base_cycles = 0;
  logic [31:0] total_cycles, load_stall_cycles, branch_stall_cycles;
  logic [31:0] taken_branches, untaken_branches;

  int nvec = 0, nfail = 0;
  logic [15:0] m_act = 0, m_pend = 0;
  int unsigned m_ald = 0, m_abr = 0, m_max = 0;
  logic [31:0] e_tot = 0, e_ld = 0, e_br = 0, e_tk = 0, e_ut = 0;

  always #10 clk = ~clk;

  stall_monitor dut (.*);

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    nvec++;
    cmp(tag, "total", total_cycles, e_tot);
    cmp(tag, "ld_stall", load_stall_cycles, e_ld);
    cmp(tag, "br_stall", branch_stall_cycles, e_br);
    cmp(tag, "taken", taken_branches, e_tk);
    cmp(tag, "untaken", untaken_branches, e_ut);
  endtask

  function automatic int unsigned hits(logic v0, logic [3:0] r0, logic v1, logic [3:0] r1);
    return ((v0 && m_act[r0]) ? 1 : 0) + ((v1 && m_act[r1]) ? 1 : 0);
  endfunction

  // reference model of one accepted beat, written from R2..R7
  task automatic model(logic f, logic l, logic ld, logic [3:0] d, logic v0, logic [3:0] r0,
                       logic v1, logic [3:0] r1, logic br, logic tk, logic [7:0] b);
    int unsigned cost;
    if (f) begin m_ald = 0; m_abr = 0; m_pend = 0; m_max = 0; end
    m_ald += 2 * hits(v0, r0, v1, r1);
    if (br && tk) m_abr += 2;
    cost = b + m_ald + m_abr;
    if (ld) m_pend[d] = 1'b1;
    if (l) e_tot += ((cost > m_max) ? cost : m_max);
    else m_max = cost;
    e_ld += m_ald;
    e_br += m_abr;
    if (br && tk) e_tk++;
    if (br && !tk) e_ut++;
    m_act = m_pend;
  endtask

  task automatic beat(string tag, logic f, logic l, logic ld, logic [3:0] d, logic v0,
                      logic [3:0] r0, logic v1, logic [3:0] r1, logic br, logic tk,
                      logic [7:0] b);
    in_valid = 1; in_first = f; in_last = l; in_is_load = ld; in_load_dst = d;
    in_src0_valid = v0; in_src0 = r0; in_src1_valid = v1; in_src1 = r1;
    in_is_branch = br; in_taken = tk; in_base_cycles = b;
    model(f, l, ld, d, v0, r0, v1, r1, br, tk, b);
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    check_all(tag);
  endtask

  task automatic idle(string tag);
    in_valid = 0; in_first = 1; in_last = 1; in_is_load = 1; in_load_dst = 4'd9;
    in_src0_valid = 1; in_src0 = 4'd9; in_src1_valid = 1; in_src1 = 4'd9;
    in_is_branch = 1; in_taken = 1; in_base_cycles = 8'd77;
    @(posedge clk); @(negedge clk);
    check_all(tag);
  endtask

  logic done = 0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_all("R1 reset");
    nvec++;
    if (in_ready !== 1'b1) begin nfail++; $display("FAIL R1 in_ready actual=%0b expected=1", in_ready); end

    // R5 plain single
    beat("R5 single", 1,1, 0,0, 0,0, 0,0, 0,0, 8'd3);
    // R2 load then use: stall 2, then both sources: 4
    beat("R2 load r3", 1,1, 1,4'd3, 0,0, 0,0, 0,0, 8'd1);
    beat("R2 use r3 one src", 1,1, 1,4'd3, 1,4'd3, 0,0, 0,0, 8'd1);
    beat("R2 use r3 two srcs", 1,1, 0,0, 1,4'd3, 1,4'd3, 0,0, 8'd1);
    // R2 window of one instruction only
    beat("R2 load r5", 1,1, 1,4'd5, 0,0, 0,0, 0,0, 8'd1);
    beat("R2 gap", 1,1, 0,0, 1,4'd1, 0,0, 0,0, 8'd1);
    beat("R2 late use", 1,1, 0,0, 1,4'd5, 0,0, 0,0, 8'd1);
    // R3 invalid source matching a loaded register
    beat("R3 load r7", 1,1, 1,4'd7, 0,0, 0,0, 0,0, 8'd1);
    beat("R3 invalid src", 1,1, 0,0, 0,4'd7, 0,4'd7, 0,0, 8'd2);
    // R4 branches
    beat("R4 taken", 1,1, 0,0, 0,0, 0,0, 1,1, 8'd1);
    beat("R4 untaken", 1,1, 0,0, 0,0, 0,0, 1,0, 8'd1);
    beat("R4 nonbranch taken flag", 1,1, 0,0, 0,0, 0,0, 0,1, 8'd1);
    // both penalties on one beat
    beat("R5 load r2", 1,1, 1,4'd2, 0,0, 0,0, 0,0, 8'd1);
    beat("R5 hit plus taken", 1,1, 0,0, 1,4'd2, 0,0, 1,1, 8'd4);
    // R6/R7 pairs: first dearer, then second dearer
    beat("R6 pair first", 1,0, 1,4'd4, 0,0, 0,0, 1,1, 8'd9);
    beat("R6 pair last", 0,1, 0,0, 1,4'd4, 0,0, 0,0, 8'd1);
    beat("R7 pair first", 1,0, 0,0, 0,0, 0,0, 0,0, 8'd1);
    beat("R7 pair last", 0,1, 0,0, 0,0, 0,0, 1,1, 8'd20);
    // R8 idle with busy-looking inputs
    idle("R8 idle a");
    idle("R8 idle b");
    beat("R8 after idle", 1,1, 0,0, 1,4'd9, 1,4'd9, 0,0, 8'd1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic pair;
      pair = ($urandom % 4) == 0;
      if (pair) begin
        beat("R6 rand first", 1,0, 1'($urandom), 4'($urandom % 4), 1'($urandom), 4'($urandom % 4),
             1'($urandom), 4'($urandom % 4), 1'($urandom), 1'($urandom), 8'($urandom));
        beat("R7 rand last", 0,1, 1'($urandom), 4'($urandom % 4), 1'($urandom), 4'($urandom % 4),
             1'($urandom), 4'($urandom % 4), 1'($urandom), 1'($urandom), 8'($urandom));
      end else begin
        beat("R5 rand single", 1,1, 1'($urandom), 4'($urandom % 4), 1'($urandom), 4'($urandom % 4),
             1'($urandom), 4'($urandom % 4), 1'($urandom), 1'($urandom), 8'($urandom));
      end
      if (($urandom % 16) == 0) idle("R8 rand idle");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule